// File: doc/BRIEF.md
# Serial Configuration Packet Receiver

This block takes a configuration bitstream that arrives one bit per clock, qualified by a valid strobe, and splits it into packets. Each packet opens with a fixed header: a run of ones, a 4-bit code, and then a field group holding a CRC enable bit, a 16-bit CRC value and a 2-bit compression field. A fixed-length data frame follows the header. The receiver hunts for the run of ones, reads the code, collects the header fields and then shifts in the frame. When a frame is complete it presents the frame word, a one-cycle ready pulse and the latched header fields to a downstream memory writer, and it counts the packets taken in.

The 4-bit code decides what happens next. One value opens a packet. A second value ends configuration and sets the done flag. Any other value restarts the whole process, which clears the packet count and the done flag. A daisy-chain output stays high until configuration is done, and after that it passes the incoming data through unchanged. A CRC error reported by an external checker freezes the receiver in a halted state. Only the restart input releases it.

Top module: `cfg_pkt_rx`

## Requirements
- R1: A header is recognised only after at least 4 consecutive valid ones. The first 0 after such a run is the first (most significant) bit of the 4-bit code. A 0 that follows fewer than 4 ones forces a restart.
- R2: After the code 4'b0010, the next 19 valid bits are the header fields in arrival order: CRC enable (1 bit), CRC value (16 bits, first bit is bit 15), compression (2 bits, first bit is bit 1). All three outputs update together on the clock edge that takes in the 19th bit.
- R3: After the header, FRAME_BITS valid bits form the frame. The first bit lands in frame_data_o[FRAME_BITS-1] and the last in bit 0. frame_rdy_o is high for exactly one cycle, starting at the edge that takes in the last frame bit.
- R4: pkt_cnt_o goes up by one with every frame_rdy_o pulse, and it is 0 after reset or any restart.
- R5: The code 4'b0100 sets cfg_done_o. After that, input bits produce no frame and leave pkt_cnt_o unchanged until a restart.
- R6: Any other 4-bit code forces a restart: restart_o pulses for one cycle, pkt_cnt_o and cfg_done_o clear, and the receiver goes back to hunting for ones.
- R7: chain_o is 1 whenever cfg_done_o is 0. When cfg_done_o is 1, chain_o equals bit_i combinationally.
- R8: crc_err_i high at a clock edge puts the receiver in a halted state (halted_o = 1). In that state input bits are ignored and no frame is produced until restart_i.
- R9: restart_i high at a clock edge clears the halted state, cfg_done_o and pkt_cnt_o, returns the receiver to hunting, and pulses restart_o.
- R10: When bit_vld_i is 0, bit_i has no effect on packet progress.
- R11: After reset: frame_rdy_o, cfg_done_o, restart_o and halted_o are 0, pkt_cnt_o is 0, and chain_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Synchronous restart of configuration |
| crc_err_i | input | 1 | CRC error from the external checker |
| bit_i | input | 1 | Serial configuration data |
| bit_vld_i | input | 1 | bit_i is valid this cycle |
| frame_data_o | output | FRAME_BITS | Most recent frame, first bit in the MSB |
| frame_rdy_o | output | 1 | One-cycle pulse when a frame is complete |
| hdr_crc_en_o | output | 1 | CRC enable field of the current packet |
| hdr_crc_o | output | 16 | CRC value field of the current packet |
| hdr_comp_o | output | 2 | Compression field of the current packet |
| pkt_cnt_o | output | CNT_W | Packets received since the last restart |
| cfg_done_o | output | 1 | End-of-configuration code was seen |
| restart_o | output | 1 | One-cycle pulse on any restart |
| halted_o | output | 1 | Receiver is halted on a CRC error |
| chain_o | output | 1 | Daisy-chain output |

## Verification
A table of packets checks the main path. The packets differ in CRC enable, CRC value, compression code and frame pattern, so a swapped field, a reversed bit order or a frame shifted by one bit shows up as a wrong value. The same packet is also sent with the valid strobe dropped between bits, while the data line holds a wrong value, so any design that samples bit_i without the strobe produces a different result. Directed sequences then try a run of only three leading ones, an unknown code, the end code, a CRC error in the middle of a header and an external restart. Together they separate a restart, a finished configuration and a halt, which each have a different effect on the count, the done flag and the chain output.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PRE,
        ST_HDR,
        ST_FRAME,
        ST_DONE,
        ST_HALT
    } rx_state_e;

    typedef enum logic [1:0] {
        PK_START,
        PK_END,
        PK_BAD
    } pre_kind_e;

    localparam int LEAD_MIN = 4;
    localparam int PRE_W    = 4;
    localparam int CRC_W    = 16;
    localparam int COMP_W   = 2;
    localparam int FIELD_W  = 1 + CRC_W + COMP_W;

    localparam logic [PRE_W-1:0] CODE_START = 4'b0010;
    localparam logic [PRE_W-1:0] CODE_END   = 4'b0100;

    // Field group in arrival order: the first bit received ends up in the MSB.
    typedef struct packed {
        logic              crc_en;
        logic [CRC_W-1:0]  crc;
        logic [COMP_W-1:0] comp;
    } hdr_fields_t;

    function automatic pre_kind_e classify_code(input logic [PRE_W-1:0] code);
        if (code == CODE_START)    return PK_START;
        else if (code == CODE_END) return PK_END;
        else                       return PK_BAD;
    endfunction

endpackage

// File: rtl/cfgrx_shift.sv
module cfgrx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)     q_r <= '0;
                else if (en) q_r <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)     q_r <= '0;
                else if (en) q_r <= {q_r[W-2:0], din};
            end
        end
    endgenerate

    assign q = q_r;
endmodule

// File: rtl/cfgrx_counter.sv
module cfgrx_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst || clr)               q_r <= '0;
        else if (inc && (q_r != '1))  q_r <= q_r + W'(1);
    end

    assign q = q_r;

    // R4: an increment that is not cleared moves the count by exactly one
    p_inc_step_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && (q != '1)) |=> (q == $past(q) + W'(1)));
endmodule

// File: rtl/cfgrx_ctrl.sv
module cfgrx_ctrl
    import cfgrx_pkg::*;
#(
    parameter int FRAME_BITS = 560
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart_i,
    input  logic                crc_err_i,
    input  logic                bit_i,
    input  logic                bit_vld_i,
    input  logic [PRE_W-2:0]    pre_q,
    output logic                pre_en,
    output logic                fld_en,
    output logic                frm_en,
    output logic                hdr_latch,
    output logic                frame_done,
    output logic                proto_restart,
    output logic                done_set,
    output rx_state_e           state_o
);
    localparam int SPAN = (FRAME_BITS > FIELD_W) ? FRAME_BITS : FIELD_W;
    localparam int CW   = $clog2(SPAN) + 1;
    localparam int OW   = $clog2(LEAD_MIN) + 1;

    rx_state_e       state;
    logic [CW-1:0]   bit_cnt;
    logic [OW-1:0]   ones_cnt;
    logic            adv;
    logic            ones_ok;
    logic            pre_last;
    logic            hdr_last;
    logic            frm_last;
    pre_kind_e       kind;

    assign adv      = bit_vld_i && !restart_i && !crc_err_i &&
                      (state != ST_DONE) && (state != ST_HALT);
    assign ones_ok  = (ones_cnt >= OW'(LEAD_MIN));
    assign pre_last = (bit_cnt == CW'(PRE_W - 1));
    assign hdr_last = (bit_cnt == CW'(FIELD_W - 1));
    assign frm_last = (bit_cnt == CW'(FRAME_BITS - 1));
    assign kind     = classify_code({pre_q, bit_i});

    always_comb begin
        pre_en        = 1'b0;
        fld_en        = 1'b0;
        frm_en        = 1'b0;
        hdr_latch     = 1'b0;
        frame_done    = 1'b0;
        proto_restart = 1'b0;
        done_set      = 1'b0;
        if (adv) begin
            case (state)
                ST_HUNT: begin
                    if (!bit_i) begin
                        if (ones_ok) pre_en        = 1'b1;
                        else         proto_restart = 1'b1;
                    end
                end
                ST_PRE: begin
                    pre_en = 1'b1;
                    if (pre_last) begin
                        if (kind == PK_END)      done_set      = 1'b1;
                        else if (kind == PK_BAD) proto_restart = 1'b1;
                    end
                end
                ST_HDR: begin
                    fld_en    = 1'b1;
                    hdr_latch = hdr_last;
                end
                ST_FRAME: begin
                    frm_en     = 1'b1;
                    frame_done = frm_last;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            state    <= ST_HUNT;
            bit_cnt  <= '0;
            ones_cnt <= '0;
        end else if (crc_err_i) begin
            state    <= ST_HALT;
        end else if (adv) begin
            case (state)
                ST_HUNT: begin
                    if (bit_i) begin
                        if (!ones_ok) ones_cnt <= ones_cnt + OW'(1);
                    end else if (ones_ok) begin
                        state   <= ST_PRE;
                        bit_cnt <= CW'(1);
                    end else begin
                        ones_cnt <= '0;
                    end
                end
                ST_PRE: begin
                    if (pre_last) begin
                        bit_cnt  <= '0;
                        ones_cnt <= '0;
                        case (kind)
                            PK_START: state <= ST_HDR;
                            PK_END:   state <= ST_DONE;
                            default:  state <= ST_HUNT;
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + CW'(1);
                    end
                end
                ST_HDR: begin
                    if (hdr_last) begin
                        state   <= ST_FRAME;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + CW'(1);
                    end
                end
                ST_FRAME: begin
                    if (frm_last) begin
                        state    <= ST_HUNT;
                        bit_cnt  <= '0;
                        ones_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o = state;

    // R10: with no valid bit, no restart and no error the state holds
    p_vld_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!bit_vld_i && !restart_i && !crc_err_i) |=> (state == $past(state)));

    // R1: the code can only start after a full run of leading ones
    p_lead_run_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRE && $past(state) == ST_HUNT) |-> ($past(ones_cnt) >= OW'(LEAD_MIN)));
endmodule

// File: rtl/cfg_pkt_rx.sv
module cfg_pkt_rx
    import cfgrx_pkg::*;
#(
    parameter int FRAME_BITS = 560,
    parameter int NUM_PKTS   = 338,
    localparam int CNT_W     = $clog2(NUM_PKTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  restart_i,
    input  logic                  crc_err_i,
    input  logic                  bit_i,
    input  logic                  bit_vld_i,
    output logic [FRAME_BITS-1:0] frame_data_o,
    output logic                  frame_rdy_o,
    output logic                  hdr_crc_en_o,
    output logic [15:0]           hdr_crc_o,
    output logic [1:0]            hdr_comp_o,
    output logic [CNT_W-1:0]      pkt_cnt_o,
    output logic                  cfg_done_o,
    output logic                  restart_o,
    output logic                  halted_o,
    output logic                  chain_o
);
    logic                 pre_en, fld_en, frm_en;
    logic                 hdr_latch, frame_done, proto_restart, done_set;
    logic [PRE_W-2:0]     pre_q;
    logic [FIELD_W-2:0]   fld_q;
    rx_state_e            state;
    hdr_fields_t          hdr_r;
    logic                 rdy_r, done_r, rst_evt_r;

    cfgrx_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .restart_i     (restart_i),
        .crc_err_i     (crc_err_i),
        .bit_i         (bit_i),
        .bit_vld_i     (bit_vld_i),
        .pre_q         (pre_q),
        .pre_en        (pre_en),
        .fld_en        (fld_en),
        .frm_en        (frm_en),
        .hdr_latch     (hdr_latch),
        .frame_done    (frame_done),
        .proto_restart (proto_restart),
        .done_set      (done_set),
        .state_o       (state)
    );

    cfgrx_shift #(.W(PRE_W - 1)) u_pre (
        .clk (clk), .rst (rst), .en (pre_en), .din (bit_i), .q (pre_q)
    );

    cfgrx_shift #(.W(FIELD_W - 1)) u_fld (
        .clk (clk), .rst (rst), .en (fld_en), .din (bit_i), .q (fld_q)
    );

    cfgrx_shift #(.W(FRAME_BITS)) u_frm (
        .clk (clk), .rst (rst), .en (frm_en), .din (bit_i), .q (frame_data_o)
    );

    cfgrx_counter #(.W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (restart_i || proto_restart),
        .inc (frame_done),
        .q   (pkt_cnt_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_r     <= '0;
            rdy_r     <= 1'b0;
            done_r    <= 1'b0;
            rst_evt_r <= 1'b0;
        end else begin
            if (hdr_latch) hdr_r <= hdr_fields_t'({fld_q, bit_i});
            rdy_r     <= frame_done;
            rst_evt_r <= restart_i || proto_restart;
            if (restart_i || proto_restart) done_r <= 1'b0;
            else if (done_set)              done_r <= 1'b1;
        end
    end

    assign frame_rdy_o  = rdy_r;
    assign hdr_crc_en_o = hdr_r.crc_en;
    assign hdr_crc_o    = hdr_r.crc;
    assign hdr_comp_o   = hdr_r.comp;
    assign cfg_done_o   = done_r;
    assign restart_o    = rst_evt_r;
    assign halted_o     = (state == ST_HALT);
    assign chain_o      = done_r ? bit_i : 1'b1;

    // R3: the ready strobe never lasts two cycles
    p_rdy_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        frame_rdy_o |=> !frame_rdy_o);

    // R4: each ready pulse comes with a count one above the previous cycle
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_rdy_o && ($past(pkt_cnt_o) != '1)) |-> (pkt_cnt_o == $past(pkt_cnt_o) + CNT_W'(1)));

    // R5: done only drops together with a restart pulse
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_done_o) && !restart_o) |-> cfg_done_o);

    // R5: no frame is delivered once configuration is done
    p_done_noframe_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |-> !frame_rdy_o);

    // R8: a halted receiver delivers no frame
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(halted_o) |-> !frame_rdy_o);

    // R9: an external restart leaves count and done cleared
    p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(restart_i) |-> (pkt_cnt_o == '0 && !cfg_done_o && !halted_o));
endmodule

// File: tb/cfg_pkt_rx_test.sv
module cfg_pkt_rx_test;
    localparam int FB    = 8;
    localparam int NP    = 338;
    localparam int CNT_W = $clog2(NP + 1);
    localparam int NVEC  = 4;

    // {crc_en, crc[15:0], comp[1:0], frame[7:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b0, 16'hAAAA, 2'b00, 8'hA5},
        {1'b1, 16'h1234, 2'b11, 8'h01},
        {1'b1, 16'hFFFF, 2'b01, 8'h80},
        {1'b0, 16'hAAAA, 2'b10, 8'h7E}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic restart_i = 1'b0;
    logic crc_err_i = 1'b0;
    logic bit_i = 1'b1;
    logic bit_vld_i = 1'b0;
    logic [FB-1:0]    frame_data_o;
    logic             frame_rdy_o, hdr_crc_en_o, cfg_done_o, restart_o, halted_o, chain_o;
    logic [15:0]      hdr_crc_o;
    logic [1:0]       hdr_comp_o;
    logic [CNT_W-1:0] pkt_cnt_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_pkt_rx #(.FRAME_BITS(FB), .NUM_PKTS(NP)) uut (
        .clk (clk), .rst (rst), .restart_i (restart_i), .crc_err_i (crc_err_i),
        .bit_i (bit_i), .bit_vld_i (bit_vld_i),
        .frame_data_o (frame_data_o), .frame_rdy_o (frame_rdy_o),
        .hdr_crc_en_o (hdr_crc_en_o), .hdr_crc_o (hdr_crc_o), .hdr_comp_o (hdr_comp_o),
        .pkt_cnt_o (pkt_cnt_o), .cfg_done_o (cfg_done_o), .restart_o (restart_o),
        .halted_o (halted_o), .chain_o (chain_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit gap);
        @(negedge clk);
        bit_i = b;
        bit_vld_i = 1'b1;
        if (gap) begin
            @(negedge clk);
            bit_vld_i = 1'b0;
            bit_i = ~b;
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input bit gap);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i], gap);
    endtask

    task automatic idle();
        @(negedge clk);
        bit_vld_i = 1'b0;
        bit_i = 1'b1;
    endtask

    task automatic send_packet(input logic [26:0] v, input bit gap);
        send_bits(32'hF, 4, gap);
        send_bits(32'b0010, 4, gap);
        send_bits(32'(v[26:8]), 19, gap);
        send_bits(32'(v[7:0]), 8, gap);
        idle();
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart_i = 1'b1;
        @(negedge clk);
        restart_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int exp_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bit_i = 1'b0;
        #1;
        // R11 reset state
        check("R11 frame_rdy", 32'(frame_rdy_o), 0);
        check("R11 done", 32'(cfg_done_o), 0);
        check("R11 halted", 32'(halted_o), 0);
        check("R11 count", 32'(pkt_cnt_o), 0);
        check("R7 chain high before config", 32'(chain_o), 1);
        bit_i = 1'b1;

        // R2 R3 R4 table of packets
        exp_cnt = 0;
        for (int k = 0; k < NVEC; k++) begin
            send_packet(VEC[k], 1'b0);
            exp_cnt++;
            check("R3 frame_rdy", 32'(frame_rdy_o), 1);
            check("R3 frame data", 32'(frame_data_o), 32'(VEC[k][7:0]));
            check("R2 crc_en", 32'(hdr_crc_en_o), 32'(VEC[k][26]));
            check("R2 crc", 32'(hdr_crc_o), 32'(VEC[k][25:10]));
            check("R2 comp", 32'(hdr_comp_o), 32'(VEC[k][9:8]));
            check("R4 count", 32'(pkt_cnt_o), 32'(exp_cnt));
            @(negedge clk);
            check("R3 pulse ends", 32'(frame_rdy_o), 0);
        end

        // R1 only three leading ones then zero
        send_bits(32'b1110, 4, 1'b0);
        idle();
        check("R1 short lead restart", 32'(restart_o), 1);
        check("R1 short lead count", 32'(pkt_cnt_o), 0);
        @(negedge clk);
        check("R6 restart pulse ends", 32'(restart_o), 0);

        // R10 valid strobe gaps with inverted data on idle cycles
        send_packet(VEC[1], 1'b1);
        check("R10 gapped frame", 32'(frame_data_o), 32'(VEC[1][7:0]));
        check("R10 gapped crc", 32'(hdr_crc_o), 32'(VEC[1][25:10]));
        check("R10 gapped count", 32'(pkt_cnt_o), 1);

        // R7 chain held high mid-frame with a zero on the line
        send_bits(32'hF, 4, 1'b0);
        send_bits(32'b0010, 4, 1'b0);
        send_bits(32'(VEC[2][26:8]), 19, 1'b0);
        send_bit(1'b0, 1'b0);
        #1;
        check("R7 chain high in progress", 32'(chain_o), 1);
        send_bits(32'(VEC[2][6:0]), 7, 1'b0);
        idle();
        check("R4 count after second", 32'(pkt_cnt_o), 2);

        // R6 unknown code
        send_bits(32'hF, 4, 1'b0);
        send_bits(32'b0110, 4, 1'b0);
        idle();
        check("R6 bad code restart", 32'(restart_o), 1);
        check("R6 bad code count", 32'(pkt_cnt_o), 0);
        check("R6 bad code done", 32'(cfg_done_o), 0);

        // R5 end code
        send_packet(VEC[0], 1'b0);
        send_bits(32'hF, 4, 1'b0);
        send_bits(32'b0100, 4, 1'b0);
        idle();
        check("R5 done set", 32'(cfg_done_o), 1);
        bit_i = 1'b0;
        #1;
        check("R7 chain follows zero", 32'(chain_o), 0);
        bit_i = 1'b1;
        #1;
        check("R7 chain follows one", 32'(chain_o), 1);
        send_packet(VEC[3], 1'b0);
        check("R5 no frame after done", 32'(frame_rdy_o), 0);
        check("R5 count frozen", 32'(pkt_cnt_o), 1);
        check("R5 frame unchanged", 32'(frame_data_o), 32'(VEC[0][7:0]));

        // R9 external restart
        pulse_restart();
        bit_i = 1'b0;
        #1;
        check("R9 restart pulse", 32'(restart_o), 1);
        check("R9 done cleared", 32'(cfg_done_o), 0);
        check("R9 count cleared", 32'(pkt_cnt_o), 0);
        check("R9 chain high again", 32'(chain_o), 1);
        bit_i = 1'b1;

        // R8 CRC error in the middle of a header
        send_bits(32'hF, 4, 1'b0);
        send_bits(32'b0010, 4, 1'b0);
        send_bits(32'h5, 3, 1'b0);
        @(negedge clk);
        bit_vld_i = 1'b0;
        crc_err_i = 1'b1;
        @(negedge clk);
        crc_err_i = 1'b0;
        check("R8 halted", 32'(halted_o), 1);
        send_packet(VEC[2], 1'b0);
        check("R8 no frame while halted", 32'(frame_rdy_o), 0);
        check("R8 count while halted", 32'(pkt_cnt_o), 0);
        check("R8 still halted", 32'(halted_o), 1);
        pulse_restart();
        check("R9 halt released", 32'(halted_o), 0);
        send_packet(VEC[2], 1'b0);
        check("R9 frame after release", 32'(frame_data_o), 32'(VEC[2][7:0]));
        check("R9 count after release", 32'(pkt_cnt_o), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule